// File: doc/BRIEF.md
# Programmable Periodic Interrupt Timer

This block raises a timed interrupt for a host processor. It runs on the system clock and advances only on a one-cycle enable, `tick`, that the timebase raises ten times a second. The host reaches the block through one 4-bit register address. A write to that address picks the interval (half a second, five seconds or a minute, or none at all) and picks whether the interrupt fires once or repeats. A read returns the interval that is currently selected.

When the interval runs out, the block asserts `irq_pull`. This is the enable of an open-drain driver that pulls the shared interrupt line low. The line stays low until the host acknowledges it. To acknowledge, the host reads the block's address three times in a row. A read at any other address in the middle of that sequence starts the count of reads again. In repeating mode the acknowledge also starts the next interval from zero. In single mode the timer stays idle until the host programs it again. The host initializes the block by writing zero and then making three reads.

Top module: `periodic_irq_timer`

## Requirements
- R1: After reset, `irq_pull` is 0 and `rdata` reads 4'b0000.
- R2: A write at the block's address selects the interval from `wdata[2:0]`. 3'b100 means 600 ticks, 3'b010 means 50 ticks and 3'b001 means 5 ticks. Any value whose low three bits are not exactly one-hot selects no interval.
- R3: Counting starts at the write. `irq_pull` rises at the clock edge that takes the tick completing the selected number of ticks, and not before.
- R4: Once asserted, `irq_pull` stays 1 through further ticks until an acknowledge or a write at the block's address.
- R5: Three consecutive reads at the block's address release `irq_pull`. Fewer than three reads leave it asserted.
- R6: A read at another address (`bus_rd`=1, `addr_hit`=0) restarts the count of acknowledge reads.
- R7: `wdata[3]`=1 selects repeating mode. The acknowledge restarts the interval from zero, and `irq_pull` rises again after a full interval of further ticks.
- R8: `wdata[3]`=0 selects single mode. After the acknowledge, no further interrupt occurs until the next write.
- R9: `rdata[2:0]` returns the selected interval code, or 3'b000 when no interval is selected. `rdata[3]` reads 0.
- R10: With no interval selected, `irq_pull` never rises.
- R11: A write at the block's address releases `irq_pull`, clears the read count and starts the new interval from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle enable, ten times a second |
| addr_hit | input | 1 | The host cycle addresses this block |
| bus_wr | input | 1 | Host write strobe, one cycle |
| bus_rd | input | 1 | Host read strobe, one cycle |
| wdata | input | 4 | Write data: interval code on bits 2..0, mode on bit 3 |
| rdata | output | 4 | Read-back of the selected interval code |
| irq_pull | output | 1 | Pull-low enable for the open-drain interrupt line |

## Verification
The bench writes all sixteen possible data values, after an initialization sequence before each one. For each value it computes the expected tick count from the code and checks the interrupt one tick before the boundary and again on it. This separates the three interval lengths and shows that codes which are not one-hot are treated as idle. Every valid code is then acknowledged with a foreign read inside the read sequence. This shows that the read count restarts and that exactly three reads release the line. For the rest of that code's run, the mode bit decides between a second full interval and silence. A final sequence rewrites the block while the interrupt is pending, to show that the release and the restart from zero come from the write alone.

// File: rtl/periodic_irq_timer.sv
module periodic_irq_timer #(
  parameter int TICKS_SHORT = 5,
  parameter int TICKS_MID   = 50,
  parameter int TICKS_LONG  = 600,
  parameter int ACK_READS   = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       addr_hit,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [3:0] wdata,
  output logic [3:0] rdata,
  output logic       irq_pull
);
  localparam int CW = $clog2(TICKS_LONG + 1);
  localparam int AW = $clog2(ACK_READS + 1);

  logic [2:0]    code;
  logic          rep, run, irq;
  logic [CW-1:0] cnt, lim;
  logic [AW-1:0] acks;

  wire own_wr   = bus_wr && addr_hit;
  wire own_rd   = bus_rd && addr_hit;
  wire other_rd = bus_rd && !addr_hit;
  wire w_valid  = $countones(wdata[2:0]) == 1;
  wire ack_now  = own_rd && (acks == AW'(ACK_READS - 1));
  wire restart  = ack_now && rep && (code != 3'b000);
  wire expire   = run && tick && (cnt == lim - 1'b1);

  always_comb begin
    case (code)
      3'b100:  lim = CW'(TICKS_LONG);
      3'b010:  lim = CW'(TICKS_MID);
      default: lim = CW'(TICKS_SHORT);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code <= 3'b000;
      rep  <= 1'b0;
      run  <= 1'b0;
      irq  <= 1'b0;
      cnt  <= '0;
      acks <= '0;
    end else if (own_wr) begin
      code <= w_valid ? wdata[2:0] : 3'b000;
      rep  <= wdata[3];
      run  <= w_valid;
      irq  <= 1'b0;
      cnt  <= '0;
      acks <= '0;
    end else begin
      if (ack_now || other_rd) acks <= '0;
      else if (own_rd)         acks <= acks + 1'b1;

      if (restart) begin
        irq <= 1'b0;
        run <= 1'b1;
        cnt <= '0;
      end else begin
        if (ack_now) irq <= 1'b0;
        if (expire) begin
          irq <= 1'b1;
          run <= 1'b0;
          cnt <= '0;
        end else if (run && tick) begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign rdata    = {1'b0, code};
  assign irq_pull = irq;
endmodule

module periodic_irq_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       addr_hit,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic [3:0] wdata,
  input logic [3:0] rdata,
  input logic       irq_pull
);
  a_r4_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pull && !(addr_hit && (bus_rd || bus_wr)) |=> irq_pull);

  a_r11_write_releases: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && addr_hit |=> !irq_pull);

  a_r3_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pull) |-> $past(tick));

  a_r10_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[2:0] == 3'b000 |=> !$rose(irq_pull));

  a_r9_readback_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && addr_hit && $onehot(wdata[2:0]) |=> rdata == {1'b0, $past(wdata[2:0])});
endmodule

bind periodic_irq_timer periodic_irq_timer_chk u_chk (.*);

// File: tb/periodic_irq_timer_test.sv
module periodic_irq_timer_test;
  logic clk = 0, rst_n = 0, tick = 0, addr_hit = 0, bus_wr = 0, bus_rd = 0;
  logic [3:0] wdata = 0;
  logic [3:0] rdata;
  logic irq_pull;
  int total = 0, bad = 0, cycles = 0;
  bit done = 0;

  periodic_irq_timer uut (.*);

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(logic [3:0] d);
    @(negedge clk); addr_hit = 1; bus_wr = 1; wdata = d;
    @(negedge clk); bus_wr = 0; addr_hit = 0;
  endtask

  task automatic do_read(logic own);
    @(negedge clk); addr_hit = own; bus_rd = 1;
    @(negedge clk); bus_rd = 0; addr_hit = 0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 irq", {3'b0, irq_pull}, 4'h0);
    check("R1 rdata", rdata, 4'h0);

    for (int v = 0; v < 16; v++) begin
      logic valid;
      int lim;
      do_write(4'h0);
      repeat (3) do_read(1);
      valid = $countones(v[2:0]) == 1;
      lim = v[2] ? 600 : (v[1] ? 50 : 5);
      do_write(v[3:0]);
      check("R9 readback", rdata, valid ? {1'b0, v[2:0]} : 4'h0);
      if (valid) begin
        ticks(lim - 1);
        check("R2/R3 before boundary", {3'b0, irq_pull}, 4'h0);
        ticks(1);
        check("R2/R3 on boundary", {3'b0, irq_pull}, 4'h1);
        ticks(3);
        check("R4 held", {3'b0, irq_pull}, 4'h1);
        do_read(1); do_read(1); do_read(0); do_read(1); do_read(1);
        check("R6 foreign read restarts count", {3'b0, irq_pull}, 4'h1);
        do_read(1);
        check("R5 third read releases", {3'b0, irq_pull}, 4'h0);
        if (v[3]) begin
          ticks(lim - 1);
          check("R7 repeat before boundary", {3'b0, irq_pull}, 4'h0);
          ticks(1);
          check("R7 repeat fires", {3'b0, irq_pull}, 4'h1);
          repeat (3) do_read(1);
          check("R5 repeat release", {3'b0, irq_pull}, 4'h0);
        end else begin
          ticks(lim + 3);
          check("R8 single stays idle", {3'b0, irq_pull}, 4'h0);
        end
      end else begin
        ticks(610);
        check("R10 no interval", {3'b0, irq_pull}, 4'h0);
      end
    end

    do_write(4'h1);
    ticks(5);
    check("R11 pending", {3'b0, irq_pull}, 4'h1);
    do_read(1);
    do_write(4'h1);
    check("R11 write releases", {3'b0, irq_pull}, 4'h0);
    ticks(4);
    check("R11 restart from zero", {3'b0, irq_pull}, 4'h0);
    ticks(1);
    check("R11 fires after full interval", {3'b0, irq_pull}, 4'h1);
    do_read(1); do_read(1);
    check("R11 read count cleared by write", {3'b0, irq_pull}, 4'h1);
    do_read(1);
    check("R5 release after write", {3'b0, irq_pull}, 4'h0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule